// File: doc/BRIEF.md
# Time Base and Decrementer

This block keeps a 64-bit time base that counts up and a 32-bit decrementer that counts down. Both advance only on cycles where the `tick` strobe is high. Some upstream logic derives `tick` from the chosen timebase frequency; the legacy real-time-clock rate is 7,812,500 Hz. Software reaches both counters through a small word-wide register port. The time base is read and written as two 32-bit halves. A read of the upper half returns the value captured when the lower half was last read, so two reads always give one coherent 64-bit value.

When the decrementer steps past zero, it reloads to all-ones and raises an exception request. A software write also raises the request when it puts a value with bit 31 set over a count whose bit 31 is clear. The request stays high until an acknowledge pulse clears it. When the real-time-clock compatibility input is high, reads and writes of the lower time-base word are masked with 0x3FFFFF80.

Top module: `timebase_decrementer`

## Requirements
- R1: After reset the time base is zero, the upper-half snapshot is zero, the decrementer is 0xFFFFFFFF and `dec_irq` is low.
- R2: Each cycle with `tick` high increments the 64-bit time base by one, and the carry propagates from the lower word into the upper word.
- R3: A write to address 0 replaces time-base bits 31:0 and keeps bits 63:32. A write to address 1 replaces bits 63:32 and keeps bits 31:0.
- R4: A read of address 1 returns time-base bits 63:32 as they were in the most recent cycle with `rd_en` high at address 0.
- R5: The decrementer is read and written at address 2. Each cycle with `tick` high lowers it by one, and it holds its value without a tick.
- R6: A tick while the decrementer is 0 loads 0xFFFFFFFF and raises `dec_irq`. Reaching 0 from 1 raises nothing.
- R7: A decrementer write with bit 31 set raises `dec_irq` when the current count has bit 31 clear. A write does not raise it when the count already has bit 31 set, or when the written value has bit 31 clear.
- R8: `dec_irq` stays high until a cycle with `dec_ack` high clears it. A new raise in the same cycle as `dec_ack` wins.
- R9: With `rtc_mode` high, address-0 reads return the lower word ANDed with 0x3FFFFF80, and address-0 writes store `wdata` ANDed with 0x3FFFFF80. Upper-word and decrementer access are unaffected.
- R10: A register write in the same cycle as a tick takes precedence: the written register takes the written value and that tick does not step it.
- R11: Address 3 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable strobe for both counters |
| rtc_mode | input | 1 | Enables the masked lower-word view |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; at address 0 it captures the upper half |
| addr | input | 2 | Register select: 0 TB lower, 1 TB upper, 2 decrementer, 3 none |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| dec_irq | output | 1 | Decrementer exception request |
| dec_ack | input | 1 | Clears `dec_irq` |

## Verification
The assertions assume that `addr` and `wr_en` are known in every cycle after reset. They also assume that `dec_ack` is a level the bench drives for whole cycles. The bench drives every input on the falling edge and never leaves any of them undefined. It makes the collision cases deliberate: a write together with a tick, and an acknowledge together with a wrap. This way the priority assertions see their antecedents fire.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    typedef enum logic [1:0] {
        SEL_TB_LO = 2'd0,
        SEL_TB_HI = 2'd1,
        SEL_DEC   = 2'd2,
        SEL_NONE  = 2'd3
    } tbd_sel_e;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
    parameter int unsigned         WORD_W   = 32,
    parameter bit                  RTC_EN   = 1'b1,
    parameter logic [WORD_W-1:0]   RTC_MASK = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rtc_mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              snap_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] lo_view,
    output logic [WORD_W-1:0] hi_snap
);
    localparam int unsigned TB_W = 2 * WORD_W;

    typedef struct packed {
        logic [TB_W-1:0]   tb;
        logic [WORD_W-1:0] snap;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [WORD_W-1:0] lo_mask;

    generate
        if (RTC_EN) begin : g_rtc
            assign lo_mask = rtc_mode ? RTC_MASK : '1;
        end else begin : g_plain
            assign lo_mask = '1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            st_d.tb[WORD_W-1:0] = wdata & lo_mask;
        end else if (wr_hi) begin
            st_d.tb[TB_W-1:WORD_W] = wdata;
        end else if (tick) begin
            st_d.tb = st_q.tb + 1'b1;
        end
        if (snap_en) begin
            st_d.snap = st_q.tb[TB_W-1:WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_view = st_q.tb[WORD_W-1:0] & lo_mask;
    assign hi_snap = st_q.snap;

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr_lo && !wr_hi |=> st_q.tb == $past(st_q.tb) + 1'b1); // R2
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi && !wr_lo |=> st_q.tb[WORD_W-1:0] == $past(st_q.tb[WORD_W-1:0])); // R3
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> st_q.tb[TB_W-1:WORD_W] == $past(st_q.tb[TB_W-1:WORD_W])); // R3
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(st_q.snap)); // R4
endmodule

// File: rtl/tbd_decr.sv
module tbd_decr #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ack,
    output logic [WORD_W-1:0] count,
    output logic              irq
);
    localparam int unsigned MSB = WORD_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] cnt;
        logic              irq;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic wrap, neg_load;

    always_comb begin
        wrap     = tick && !wr && (st_q.cnt == '0);
        neg_load = wr && wdata[MSB] && !st_q.cnt[MSB];
        st_d     = st_q;
        if (wr) begin
            st_d.cnt = wdata;
        end else if (tick) begin
            st_d.cnt = wrap ? '1 : st_q.cnt - 1'b1;
        end
        if (wrap || neg_load) begin
            st_d.irq = 1'b1;
        end else if (ack) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign irq   = st_q.irq;

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr && st_q.cnt != '0 |=> st_q.cnt == $past(st_q.cnt) - 1'b1); // R5
    AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !wr && st_q.cnt == '0 |=> st_q.cnt == '1 && st_q.irq); // R6
    AST_NEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr && wdata[MSB] && !st_q.cnt[MSB] |=> st_q.irq); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq && !ack |=> st_q.irq); // R8
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !wr && !tick |=> !st_q.irq); // R8
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> st_q.cnt == $past(wdata)); // R10
endmodule

// File: rtl/timebase_decrementer.sv
module timebase_decrementer
    import tbd_pkg::*;
#(
    parameter int unsigned       WORD_W   = 32,
    parameter bit                RTC_EN   = 1'b1,
    parameter logic [WORD_W-1:0] RTC_MASK = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rtc_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              dec_irq,
    input  logic              dec_ack
);
    tbd_sel_e sel;
    logic wr_lo, wr_hi, wr_dec, snap_en;
    logic [WORD_W-1:0] lo_view, hi_snap, dec_cnt;

    always_comb begin
        sel     = tbd_sel_e'(addr);
        wr_lo   = wr_en && (sel == SEL_TB_LO);
        wr_hi   = wr_en && (sel == SEL_TB_HI);
        wr_dec  = wr_en && (sel == SEL_DEC);
        snap_en = rd_en && (sel == SEL_TB_LO);
    end

    tbd_timebase #(
        .WORD_W  (WORD_W),
        .RTC_EN  (RTC_EN),
        .RTC_MASK(RTC_MASK)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rtc_mode(rtc_mode),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .snap_en (snap_en),
        .wdata   (wdata),
        .lo_view (lo_view),
        .hi_snap (hi_snap)
    );

    tbd_decr #(
        .WORD_W(WORD_W)
    ) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .wr   (wr_dec),
        .wdata(wdata),
        .ack  (dec_ack),
        .count(dec_cnt),
        .irq  (dec_irq)
    );

    always_comb begin
        unique case (sel)
            SEL_TB_LO: rdata = lo_view;
            SEL_TB_HI: rdata = hi_snap;
            SEL_DEC:   rdata = dec_cnt;
            default:   rdata = '0;
        endcase
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_lo, wr_hi, wr_dec}) <= 1); // R11
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_irq) |-> $past(tick) || $past(wr_dec)); // R6
endmodule

// File: tb/timebase_decrementer_tb.sv
module timebase_decrementer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        rtc_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        dec_irq;
    logic        dec_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    timebase_decrementer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rtc_mode(rtc_mode),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dec_irq(dec_irq), .dec_ack(dec_ack)
    );

    // {wr, addr[1:0], rtc, data[31:0], expected[31:0]}
    localparam logic [67:0] VEC [0:8] = '{
        {1'b1, 2'd0, 1'b0, 32'h1234_5678, 32'h1234_5678},
        {1'b1, 2'd1, 1'b0, 32'hCAFE_BABE, 32'hCAFE_BABE},
        {1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h1234_5678},
        {1'b1, 2'd0, 1'b1, 32'hFFFF_FFFF, 32'h3FFF_FF80},
        {1'b0, 2'd0, 1'b0, 32'h0000_0000, 32'h3FFF_FF80},
        {1'b1, 2'd2, 1'b1, 32'h0000_0010, 32'h0000_0010},
        {1'b1, 2'd3, 1'b0, 32'h0000_AAAA, 32'h0000_0000},
        {1'b0, 2'd1, 1'b1, 32'h0000_0000, 32'hCAFE_BABE},
        {1'b0, 2'd2, 1'b0, 32'h0000_0000, 32'h0000_0010}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        if (a == 2'd1) begin
            @(negedge clk);
            rd_en = 1'b1; addr = 2'd0;
            @(negedge clk);
            rd_en = 1'b0;
        end
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 tb lower", v, 32'h0);
        @(negedge clk); addr = 2'd1; #1 check("R1 snapshot", rdata, 32'h0);
        rd(2'd2, v); check("R1 dec", v, 32'hFFFF_FFFF);
        check("R1 irq", {31'h0, dec_irq}, 32'h0);

        // table: R3 R4 R5 R9 R11
        for (int i = 0; i < 9; i++) begin
            logic [67:0] e;
            e = VEC[i];
            @(negedge clk);
            rtc_mode = e[64];
            if (e[67]) wr(e[66:65], e[63:32]);
            rd(e[66:65], v);
            check($sformatf("R3/R4/R5/R9/R11 vector %0d", i), v, e[31:0]);
        end
        @(negedge clk); rtc_mode = 1'b0;

        // R2 carry into upper word
        wr(2'd0, 32'hFFFF_FFFE);
        wr(2'd1, 32'h0);
        ticks(3);
        rd(2'd1, v); check("R2 upper after carry", v, 32'h1);
        rd(2'd0, v); check("R2 lower after carry", v, 32'h1);

        // R5 count down, hold without tick
        wr(2'd2, 32'd5);
        ticks(3);
        rd(2'd2, v); check("R5 after 3 ticks", v, 32'd2);
        repeat (4) @(negedge clk);
        #1 check("R5 hold", rdata, 32'd2);
        check("R5 no irq", {31'h0, dec_irq}, 32'h0);

        // R6 wrap
        wr(2'd2, 32'd1);
        ticks(1);
        rd(2'd2, v); check("R6 reach zero", v, 32'h0);
        check("R6 no irq at zero", {31'h0, dec_irq}, 32'h0);
        ticks(1);
        rd(2'd2, v); check("R6 reload", v, 32'hFFFF_FFFF);
        check("R6 irq raised", {31'h0, dec_irq}, 32'h1);

        // R8 hold then ack
        repeat (5) @(negedge clk);
        check("R8 held", {31'h0, dec_irq}, 32'h1);
        @(negedge clk); dec_ack = 1'b1;
        @(negedge clk); dec_ack = 1'b0;
        check("R8 cleared", {31'h0, dec_irq}, 32'h0);

        // R7 negative write over negative count
        wr(2'd2, 32'h8000_0000);
        check("R7 neg over neg", {31'h0, dec_irq}, 32'h0);
        wr(2'd2, 32'd5);
        check("R7 pos over neg", {31'h0, dec_irq}, 32'h0);
        wr(2'd2, 32'h9000_0000);
        check("R7 neg over pos", {31'h0, dec_irq}, 32'h1);
        @(negedge clk); dec_ack = 1'b1;
        @(negedge clk); dec_ack = 1'b0;
        wr(2'd2, 32'd7);
        check("R7 pos over pos", {31'h0, dec_irq}, 32'h0);

        // R8 raise wins over simultaneous ack
        wr(2'd2, 32'h8000_0000);
        wr(2'd2, 32'h0);
        check("R8 irq before collision", {31'h0, dec_irq}, 32'h1);
        @(negedge clk); dec_ack = 1'b1; dec_ack = 1'b1;
        @(negedge clk); dec_ack = 1'b0;
        check("R8 plain ack", {31'h0, dec_irq}, 32'h0);
        @(negedge clk); tick = 1'b1; dec_ack = 1'b1;
        @(negedge clk); tick = 1'b0; dec_ack = 1'b0;
        check("R8 wrap beats ack", {31'h0, dec_irq}, 32'h1);

        // R10 write beats tick
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 32'd100;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        rd(2'd2, v); check("R10 dec write wins", v, 32'd100);
        @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 32'h50;
        @(negedge clk); tick = 1'b0; wr_en = 1'b0;
        rd(2'd0, v); check("R10 tb write wins", v, 32'h50);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule